// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads descriptors from a translation table in physical memory. A requester hands over the virtual address, the table base register and a flag that enables the fine-table / 1 KB-page format, all in one accept cycle. The walker then reads one descriptor word, or two, through a single-outstanding read port. Those fetch addresses are physical and are never translated themselves.

The first-level word decides how the walk continues. It can fault, it can map a 1 MB region directly, or it can point at a second-level table. That table is either coarse (256 entries) or fine (1024 entries). The second-level word then maps a 64 KB, 4 KB or 1 KB page. Each walk ends with a one-cycle completion pulse. The pulse carries a fault flag, the physical address and two cacheable/bufferable attribute bits. The walker takes no new request until that pulse has gone by.

Top module: `ptw_walker`

## Requirements
- R1: The first fetch address is {base[31:14], va[31:20], 2'b00}, where base is the table base register sampled when the request is accepted.
- R2: A first-level word whose bits [1:0] are 2'b00 ends the walk with done_fault=1 and no second fetch. On any fault, done_pa and done_attr read zero.
- R3: A first-level type of 2'b10 maps a region. done_pa = {d1[31:20], va[19:0]} and done_attr = d1[3:2], with a single fetch.
- R4: A first-level type of 2'b01 (coarse table) causes a second fetch at {d1[31:10], va[19:12], 2'b00}.
- R5: A first-level type of 2'b11 with the tiny flag set (fine table) causes a second fetch at {d1[31:12], va[19:10], 2'b00}.
- R6: A first-level type of 2'b11 with the tiny flag clear is a fault, with no second fetch.
- R7: A second-level word whose bits [1:0] are 2'b00 is a fault.
- R8: Second-level types map pages as follows. 2'b01 gives {d2[31:16], va[15:0]}. 2'b10 gives {d2[31:12], va[11:0]}. 2'b11 gives {d2[31:10], va[9:0]}. In every case done_attr = d2[3:2].
- R9: An error response on either fetch ends the walk as a fault, and nothing further is fetched.
- R10: mem_rd_valid and mem_rd_addr stay constant until mem_rd_ready. At most one read is outstanding, and a walk issues exactly one or two reads.
- R11: req_ready is low from the cycle after acceptance until the cycle after the done pulse. Requests offered in that window are ignored. done is high for exactly one cycle per walk.
- R12: After reset, req_ready=1, mem_rd_valid=0 and done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_va | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | Table base register (bits 31:14 used) |
| req_tiny_en | input | 1 | Enables fine tables / 1 KB pages |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Physical word address of the descriptor |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk faulted |
| done_pa | output | 32 | Translated physical address |
| done_attr | output | 2 | Cacheable/bufferable bits |

## Verification
A corrupted latched virtual address or table base would show up on mem_rd_addr at the first fetch request. That is one cycle after acceptance. A wrong descriptor-type decode would show up either as a missing or extra second fetch, visible at mem_rd_valid one cycle after the response, or as a wrong done_pa, done_attr or done_fault on the done pulse. A stuck sequencer would leave req_ready low, or raise done twice, within a cycle of the point where the walk should have finished. The bench sweeps every first- and second-level type against several address patterns, tiny-flag settings, port latencies and error placements.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT,
      ST_DONE
   } walk_state_e;

   typedef enum logic [1:0] {
      L1K_FAULT,
      L1K_REGION,
      L1K_TABLE
   } l1_kind_e;

   // descriptor type codes in bits [1:0]
   localparam logic [1:0] DT_NONE = 2'b00;
   localparam logic [1:0] DT_T01  = 2'b01;
   localparam logic [1:0] DT_T10  = 2'b10;
   localparam logic [1:0] DT_T11  = 2'b11;
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
   import ptw_pkg::*;
#(
   parameter int AW          = 32,
   parameter int SECT_OFF_W  = 20,
   parameter int SMALL_OFF_W = 12,
   parameter int TINY_OFF_W  = 10,
   parameter int ATTR_LSB    = 2,
   parameter int ATTR_W      = 2,
   parameter int WORD_LSB    = 2
) (
   input  logic [AW-1:0]     desc,
   input  logic [AW-1:0]     va,
   input  logic              tiny_en,
   output l1_kind_e          kind,
   output logic [AW-1:0]     next_addr,
   output logic [AW-1:0]     region_pa,
   output logic [ATTR_W-1:0] attr
);
   localparam int COARSE_LSB = SECT_OFF_W - SMALL_OFF_W + WORD_LSB;
   localparam int FINE_LSB   = SECT_OFF_W - TINY_OFF_W + WORD_LSB;
   localparam int N_TBL      = 2;

   logic [AW-1:0] tbl_addr [N_TBL];

   genvar g;
   generate
      for (g = 0; g < N_TBL; g++) begin : g_tbl
         localparam int IDX_LO = (g == 0) ? SMALL_OFF_W : TINY_OFF_W;
         localparam int BASE_LSB = (g == 0) ? COARSE_LSB : FINE_LSB;
         if (WORD_LSB > 0) begin : g_pad
            assign tbl_addr[g] = {desc[AW-1:BASE_LSB], va[SECT_OFF_W-1:IDX_LO],
                                  {WORD_LSB{1'b0}}};
         end else begin : g_nopad
            assign tbl_addr[g] = {desc[AW-1:BASE_LSB], va[SECT_OFF_W-1:IDX_LO]};
         end
      end
   endgenerate

   assign region_pa = {desc[AW-1:SECT_OFF_W], va[SECT_OFF_W-1:0]};
   assign attr      = desc[ATTR_LSB +: ATTR_W];

   always_comb begin
      kind      = L1K_FAULT;
      next_addr = tbl_addr[0];
      unique case (desc[1:0])
         DT_NONE: kind = L1K_FAULT;
         DT_T10:  kind = L1K_REGION;
         DT_T01: begin
            kind      = L1K_TABLE;
            next_addr = tbl_addr[0];
         end
         DT_T11: begin
            kind      = tiny_en ? L1K_TABLE : L1K_FAULT;
            next_addr = tbl_addr[1];
         end
         default: kind = L1K_FAULT;
      endcase
   end

   logic unused_l1;
   assign unused_l1 = ^{desc[COARSE_LSB-1:ATTR_LSB+ATTR_W], va[TINY_OFF_W-1:0]};
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
   import ptw_pkg::*;
#(
   parameter int AW          = 32,
   parameter int LARGE_OFF_W = 16,
   parameter int SMALL_OFF_W = 12,
   parameter int TINY_OFF_W  = 10,
   parameter int ATTR_LSB    = 2,
   parameter int ATTR_W      = 2
) (
   input  logic [AW-1:0]     desc,
   input  logic [AW-1:0]     va,
   output logic              fault,
   output logic [AW-1:0]     page_pa,
   output logic [ATTR_W-1:0] attr
);
   localparam int N_PG = 3;

   logic [AW-1:0] cand [N_PG];

   genvar g;
   generate
      for (g = 0; g < N_PG; g++) begin : g_pg
         localparam int OW = (g == 0) ? LARGE_OFF_W :
                             (g == 1) ? SMALL_OFF_W : TINY_OFF_W;
         assign cand[g] = {desc[AW-1:OW], va[OW-1:0]};
      end
   endgenerate

   assign attr = desc[ATTR_LSB +: ATTR_W];

   always_comb begin
      fault   = 1'b0;
      page_pa = cand[0];
      unique case (desc[1:0])
         DT_NONE: fault   = 1'b1;
         DT_T01:  page_pa = cand[0];
         DT_T10:  page_pa = cand[1];
         DT_T11:  page_pa = cand[2];
         default: fault   = 1'b1;
      endcase
   end

   logic unused_l2;
   assign unused_l2 = ^{desc[TINY_OFF_W-1:ATTR_LSB+ATTR_W], va[AW-1:LARGE_OFF_W]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int AW          = 32,
   parameter int SECT_OFF_W  = 20,
   parameter int LARGE_OFF_W = 16,
   parameter int SMALL_OFF_W = 12,
   parameter int TINY_OFF_W  = 10,
   parameter int ATTR_LSB    = 2,
   parameter int ATTR_W      = 2,
   parameter int WORD_LSB    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AW-1:0]     req_va,
   input  logic [AW-1:0]     req_ttb,
   input  logic              req_tiny_en,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [AW-1:0]     mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [AW-1:0]     mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              done,
   output logic              done_fault,
   output logic [AW-1:0]     done_pa,
   output logic [ATTR_W-1:0] done_attr
);
   localparam int TB_LSB = AW - SECT_OFF_W + WORD_LSB;

   generate
      if (!(SECT_OFF_W > LARGE_OFF_W && LARGE_OFF_W > SMALL_OFF_W &&
            SMALL_OFF_W > TINY_OFF_W)) begin : g_chk_order
         $error("page offset widths must strictly shrink");
      end
      if (TINY_OFF_W < ATTR_LSB + ATTR_W) begin : g_chk_attr
         $error("attribute field overlaps smallest page base");
      end
      if (ATTR_LSB < 2) begin : g_chk_type
         $error("attribute field overlaps type bits");
      end
      if (TB_LSB >= AW || SECT_OFF_W >= AW || WORD_LSB < 1) begin : g_chk_aw
         $error("address width too small for table layout");
      end
   endgenerate

   walk_state_e       state_q;
   logic [AW-1:0]     va_q;
   logic              tiny_q;
   logic [AW-1:0]     rd_addr_q;
   logic              fault_q;
   logic [AW-1:0]     pa_q;
   logic [ATTR_W-1:0] attr_q;

   logic [AW-1:0]     l1_addr;
   l1_kind_e          l1_kind;
   logic [AW-1:0]     l1_next;
   logic [AW-1:0]     l1_pa;
   logic [ATTR_W-1:0] l1_attr;
   logic              l2_fault;
   logic [AW-1:0]     l2_pa;
   logic [ATTR_W-1:0] l2_attr;

   assign l1_addr = {req_ttb[AW-1:TB_LSB], req_va[AW-1:SECT_OFF_W], {WORD_LSB{1'b0}}};

   ptw_l1_decode #(
      .AW(AW), .SECT_OFF_W(SECT_OFF_W), .SMALL_OFF_W(SMALL_OFF_W),
      .TINY_OFF_W(TINY_OFF_W), .ATTR_LSB(ATTR_LSB), .ATTR_W(ATTR_W),
      .WORD_LSB(WORD_LSB)
   ) i_l1 (
      .desc      (mem_rsp_data),
      .va        (va_q),
      .tiny_en   (tiny_q),
      .kind      (l1_kind),
      .next_addr (l1_next),
      .region_pa (l1_pa),
      .attr      (l1_attr)
   );

   ptw_l2_decode #(
      .AW(AW), .LARGE_OFF_W(LARGE_OFF_W), .SMALL_OFF_W(SMALL_OFF_W),
      .TINY_OFF_W(TINY_OFF_W), .ATTR_LSB(ATTR_LSB), .ATTR_W(ATTR_W)
   ) i_l2 (
      .desc    (mem_rsp_data),
      .va      (va_q),
      .fault   (l2_fault),
      .page_pa (l2_pa),
      .attr    (l2_attr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         va_q      <= '0;
         tiny_q    <= 1'b0;
         rd_addr_q <= '0;
         fault_q   <= 1'b0;
         pa_q      <= '0;
         attr_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q      <= req_va;
                  tiny_q    <= req_tiny_en;
                  rd_addr_q <= l1_addr;
                  state_q   <= ST_L1_REQ;
               end
            end
            ST_L1_REQ: if (mem_rd_ready) state_q <= ST_L1_WAIT;
            ST_L1_WAIT: begin
               if (mem_rsp_valid) begin
                  fault_q <= 1'b1;
                  pa_q    <= '0;
                  attr_q  <= '0;
                  state_q <= ST_DONE;
                  if (!mem_rsp_err) begin
                     if (l1_kind == L1K_REGION) begin
                        fault_q <= 1'b0;
                        pa_q    <= l1_pa;
                        attr_q  <= l1_attr;
                     end else if (l1_kind == L1K_TABLE) begin
                        fault_q   <= 1'b0;
                        rd_addr_q <= l1_next;
                        state_q   <= ST_L2_REQ;
                     end
                  end
               end
            end
            ST_L2_REQ: if (mem_rd_ready) state_q <= ST_L2_WAIT;
            ST_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  state_q <= ST_DONE;
                  if (mem_rsp_err || l2_fault) begin
                     fault_q <= 1'b1;
                     pa_q    <= '0;
                     attr_q  <= '0;
                  end else begin
                     fault_q <= 1'b0;
                     pa_q    <= l2_pa;
                     attr_q  <= l2_attr;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign mem_rd_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
   assign mem_rd_addr  = rd_addr_q;
   assign done         = (state_q == ST_DONE);
   assign done_fault   = fault_q;
   assign done_pa      = pa_q;
   assign done_attr    = attr_q;

   logic unused_top;
   assign unused_top = ^req_ttb[TB_LSB-1:0];
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int AW     = 32,
   parameter int ATTR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [AW-1:0]     mem_rd_addr,
   input logic              mem_rsp_valid,
   input logic              done,
   input logic              done_fault,
   input logic [AW-1:0]     done_pa,
   input logic [ATTR_W-1:0] done_attr
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else if (mem_rd_valid && mem_rd_ready) pend_q <= 1'b1;
      else if (mem_rsp_valid) pend_q <= 1'b0;
   end

   assert_hold_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

   assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !mem_rd_valid);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   assert_no_read_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd_valid && !req_ready);

   assert_fault_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_fault |-> done_pa == '0 && done_attr == '0);
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW), .ATTR_W(ATTR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
   .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
   .done(done), .done_fault(done_fault), .done_pa(done_pa), .done_attr(done_attr)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic [31:0] req_ttb = '0;
   logic        req_tiny_en = 1'b0;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic        done;
   logic        done_fault;
   logic [31:0] done_pa;
   logic [1:0]  done_attr;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   ptw_walker i_ptw_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_ttb(req_ttb), .req_tiny_en(req_tiny_en),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .done(done), .done_fault(done_fault), .done_pa(done_pa), .done_attr(done_attr)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic walk(input logic [31:0] va, ttb, d1, d2, input logic tiny, e1, e2,
                       input int lat, input logic poke,
                       output int n, output logic [31:0] a1, a2, pa,
                       output logic flt, output logic [1:0] attr,
                       output logic busy_bad, output logic seen);
      int guard;
      n = 0; a1 = '0; a2 = '0; pa = '0; flt = 1'b0; attr = '0;
      busy_bad = 1'b0; seen = 1'b0; guard = 0;
      @(negedge clk);
      req_va = va; req_ttb = ttb; req_tiny_en = tiny; req_valid = 1'b1;
      @(negedge clk);
      if (poke) begin
         req_va = ~va; req_ttb = ~ttb; req_tiny_en = ~tiny;
      end else req_valid = 1'b0;
      while (!seen && guard < 400) begin
         guard++;
         if (req_ready) busy_bad = 1'b1;
         if (done) begin
            seen = 1'b1; flt = done_fault; pa = done_pa; attr = done_attr;
            req_valid = 1'b0;
         end else if (mem_rd_valid) begin
            for (int k = 0; k < lat; k++) begin
               @(negedge clk);
               if (req_ready) busy_bad = 1'b1;
            end
            if (n == 0) a1 = mem_rd_addr; else a2 = mem_rd_addr;
            mem_rd_ready = 1'b1;
            @(negedge clk);
            mem_rd_ready = 1'b0;
            for (int k = 0; k < lat; k++) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = (n == 0) ? d1 : d2;
            mem_rsp_err   = (n == 0) ? e1 : e2;
            n++;
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
         end else @(negedge clk);
      end
   endtask

   task automatic run_case(input logic [31:0] va, ttb, d1, d2, input logic tiny, e1, e2,
                           input int lat, input logic poke);
      int en, n;
      logic [31:0] ea1, ea2, epa, a1, a2, pa;
      logic ef, flt, busy_bad, seen;
      logic [1:0] eattr, attr;
      string ftag, ptag, atag;
      // expected values from the requirements
      ea1 = {ttb[31:14], va[31:20], 2'b00};
      ea2 = '0; en = 1; ef = 1'b1; epa = '0; eattr = '0;
      ftag = "R2"; ptag = "R3"; atag = "R4";
      if (e1) ftag = "R9";
      else if (d1[1:0] == 2'b00) ftag = "R2";
      else if (d1[1:0] == 2'b10) begin
         ef = 1'b0; epa = {d1[31:20], va[19:0]}; eattr = d1[3:2]; ftag = "R3";
      end else if (d1[1:0] == 2'b11 && !tiny) ftag = "R6";
      else begin
         en = 2;
         if (d1[1:0] == 2'b01) begin ea2 = {d1[31:10], va[19:12], 2'b00}; atag = "R4"; end
         else begin ea2 = {d1[31:12], va[19:10], 2'b00}; atag = "R5"; end
         ptag = "R8";
         if (e2) ftag = "R9";
         else if (d2[1:0] == 2'b00) ftag = "R7";
         else begin
            ef = 1'b0; ftag = "R8"; eattr = d2[3:2];
            case (d2[1:0])
               2'b01:   epa = {d2[31:16], va[15:0]};
               2'b10:   epa = {d2[31:12], va[11:0]};
               default: epa = {d2[31:10], va[9:0]};
            endcase
         end
      end
      walk(va, ttb, d1, d2, tiny, e1, e2, lat, poke, n, a1, a2, pa, flt, attr, busy_bad, seen);
      chk(seen, "R11 done seen", {31'd0, seen}, 32'd1);
      chk(n == en, "R10 read count", n, en);
      chk(a1 == ea1, "R1 first fetch address", a1, ea1);
      if (en == 2) chk(a2 == ea2, {atag, " second fetch address"}, a2, ea2);
      chk(flt == ef, {ftag, " fault flag"}, {31'd0, flt}, {31'd0, ef});
      chk(pa == epa, {ptag, " physical address"}, pa, epa);
      chk(attr == eattr, {ptag, " attribute bits"}, {30'd0, attr}, {30'd0, eattr});
      chk(!busy_bad, "R11 req_ready low while busy", {31'd0, busy_bad}, 32'd0);
      @(negedge clk);
      chk(!done && req_ready, "R11 pulse ends and ready returns",
          {30'd0, done, req_ready}, 32'd1);
   endtask

   initial begin
      logic [31:0] vas [3];
      logic [31:0] ttbs [3];
      vas[0] = 32'hFFFF_FFFF; vas[1] = 32'h1234_5678; vas[2] = 32'hA5C3_3C5A;
      ttbs[0] = 32'h8765_4321; ttbs[1] = 32'h0000_3FFF; ttbs[2] = 32'hFFFF_C000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R12 req_ready after reset", {31'd0, req_ready}, 32'd1);
      chk(mem_rd_valid == 1'b0, "R12 no read after reset", {31'd0, mem_rd_valid}, 32'd0);
      chk(done == 1'b0, "R12 done low after reset", {31'd0, done}, 32'd0);

      for (int vi = 0; vi < 3; vi++) begin
         for (int t1 = 0; t1 < 4; t1++) begin
            for (int ti = 0; ti < 2; ti++) begin
               for (int t2 = 0; t2 < 4; t2++) begin
                  logic [31:0] d1, d2;
                  if ((t1 == 0 || t1 == 2) && t2 > 0) continue;
                  d1 = (32'h9E37_79B9 * (vi + 1) + 32'h1111 * t1) & 32'hFFFF_FFF0;
                  d1 = d1 | (32'((vi + t1) % 4) << 2) | 32'(t1);
                  d2 = (32'h7F4A_7C15 * (t2 + 3) ^ vas[vi]) & 32'hFFFF_FFF0;
                  d2 = d2 | (32'((t2 + ti + vi) % 4) << 2) | 32'(t2);
                  run_case(vas[vi], ttbs[vi], d1, d2, ti[0], 1'b0, 1'b0,
                           (vi + t2) % 3, t2[0]);
               end
            end
         end
      end

      // error responses on first and second fetch (R9)
      for (int vi = 0; vi < 3; vi++) begin
         run_case(vas[vi], ttbs[vi], 32'hCAFE_F00E, 32'h1234_5006, 1'b1, 1'b1, 1'b0, vi, 1'b0);
         run_case(vas[vi], ttbs[vi], 32'hCAFE_F00D, 32'h1234_500A, 1'b1, 1'b0, 1'b1, vi, 1'b1);
         run_case(vas[vi], ttbs[vi], 32'hCAFE_F00F, 32'h1234_500B, 1'b1, 1'b0, 1'b1, 2 - vi, 1'b0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule